// File: doc/BRIEF.md
# PWM Realignment Drift Meter

This block estimates how far apart two oscillators run. Each oscillator drives its own free-running PWM at the same nominal rate, for example 10 kHz, which is a 100 µs period. Because the two clocks differ slightly, the rising edges of the two PWM waveforms slide past each other. Now and then they line up again. Between two such line-ups, the slower waveform completes N periods and the faster one completes N+1. The relative period error is then about 2/(2N+1). N is also roughly the time between line-ups divided by the switching period. Line-ups are expected from a few seconds to more than 20 seconds apart, which means N can exceed 200,000.

The meter brings both PWM inputs into the system clock domain and finds their rising edges. It declares a coincidence when the two edges land within a programmable window of system clocks. After each coincidence it ignores a programmable number of reference periods, so that one slow alignment is not counted twice. It counts the reference rising edges from one coincidence to the next and reports that count with a one-cycle strobe. It can also report the same interval in system clocks. Software turns the count into parts per million.

Top module: `drift_meter`

## Requirements
- R1: While reset is asserted and after it is released, the strobe, the period count, the overflow flag and the clock count all read zero until the first report.
- R2: Each PWM input passes through a two-flop synchronizer and then a rising-edge detector. An edge sampled on clock edge k can produce a strobe on clock edge k+3 at the earliest.
- R3: A coincidence is declared when one input rises in the same cycle as the other, or up to W cycles after an unconsumed rise of the other, where W is the window setting. A window of 0 means same-cycle only. A coincidence consumes both pending rises.
- R4: The first coincidence after reset only arms the meter. Every later coincidence produces a strobe that is exactly one cycle wide.
- R5: After a coincidence, no new coincidence is accepted until B further reference rises have passed, where B is the blanking setting.
- R6: The reported period count equals the number of reference rises after the previous coincidence, up to and including the current one. The count saturates at 2^CNT_W-1, and the overflow flag is 1 exactly when the true count is larger than that.
- R7: With the elapsed-time option on, the clock count equals the number of cycles between the two coincidence cycles, saturating at 2^TIME_W-1. With the option off, the clock count reads zero.
- R8: The period count, the overflow flag and the clock count hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| pwm_ref_i | input | 1 | Reference PWM, asynchronous |
| pwm_cmp_i | input | 1 | Compared PWM, asynchronous |
| win_cfg_i | input | WIN_W | Coincidence window in system clocks |
| blank_cfg_i | input | BLANK_W | Reference rises ignored after a coincidence |
| meas_valid_o | output | 1 | One-cycle strobe for a new result |
| meas_periods_o | output | CNT_W | Reference periods between coincidences |
| meas_ovf_o | output | 1 | Period count saturated |
| meas_clocks_o | output | TIME_W | System clocks between coincidences |

## Verification
The bench builds the meter with a 6-bit period counter and a 10-bit clock counter. This lets a pair of PWM periods of 100 and 101 clocks push both counters into saturation within a few tens of thousands of cycles. Short PWM periods of 8 to 11 clocks give many line-ups, so the bench exercises:
- several window widths;
- phase offsets between the two inputs;
- near-miss edges that would be counted twice without blanking.

A second copy of the meter, built with the elapsed-time option off, runs alongside the first.

// File: rtl/drift_meter_pkg.sv
package drift_meter_pkg;

   // rising-edge pulses of the two channels, one system clock wide
   typedef struct packed {
      logic cmp;
      logic ref_e;
   } edge_pair_t;

   localparam int unsigned CH_REF = 0;
   localparam int unsigned CH_CMP = 1;
   localparam int unsigned N_CH   = 2;

endpackage

// File: rtl/dm_edge_sync.sv
module dm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dm_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;

   // R2
   rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);

endmodule

// File: rtl/dm_coincide.sv
module dm_coincide
   import drift_meter_pkg::*;
#(
   parameter int WIN_W   = 8,
   parameter int BLANK_W = 12
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  edge_pair_t         rise_i,
   input  logic [WIN_W-1:0]   win_cfg_i,
   input  logic [BLANK_W-1:0] blank_cfg_i,
   output logic               coin_o,
   output logic               coin_ref_o
);

   logic [WIN_W-1:0]   ref_tmr_q, cmp_tmr_q;
   logic [BLANK_W-1:0] blank_q;
   logic               ref_open, cmp_open, raw_hit;

   assign ref_open = (ref_tmr_q != '0);
   assign cmp_open = (cmp_tmr_q != '0);
   assign raw_hit  = (rise_i.ref_e & (rise_i.cmp | cmp_open)) |
                     (rise_i.cmp & ref_open);
   assign coin_o     = raw_hit & (blank_q == '0);
   assign coin_ref_o = coin_o & rise_i.ref_e;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ref_tmr_q <= '0;
         cmp_tmr_q <= '0;
         blank_q   <= '0;
      end else if (coin_o) begin
         ref_tmr_q <= '0;
         cmp_tmr_q <= '0;
         blank_q   <= blank_cfg_i;
      end else begin
         if (rise_i.ref_e)  ref_tmr_q <= win_cfg_i;
         else if (ref_open) ref_tmr_q <= ref_tmr_q - 1'b1;
         if (rise_i.cmp)    cmp_tmr_q <= win_cfg_i;
         else if (cmp_open) cmp_tmr_q <= cmp_tmr_q - 1'b1;
         if (rise_i.ref_e && blank_q != '0) blank_q <= blank_q - 1'b1;
      end
   end

   // R3
   pend_consumed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      coin_o |=> (ref_tmr_q == '0 && cmp_tmr_q == '0));

   // R5
   blank_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      coin_o |=> (blank_q == $past(blank_cfg_i)));

endmodule

// File: rtl/dm_interval.sv
module dm_interval #(
   parameter int CNT_W   = 24,
   parameter int TIME_W  = 32,
   parameter bit TIME_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              coin_i,
   input  logic              coin_ref_i,
   input  logic              ref_rise_i,
   output logic              valid_o,
   output logic [CNT_W-1:0]  periods_o,
   output logic              ovf_o,
   output logic [TIME_W-1:0] clocks_o
);

   localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [TIME_W-1:0] TIME_MAX = {TIME_W{1'b1}};

   logic             armed_q, sat_q;
   logic [CNT_W-1:0] cnt_q, cnt_final;
   logic             at_max, ovf_final;

   assign at_max    = (cnt_q == CNT_MAX);
   assign cnt_final = (coin_ref_i && !at_max) ? cnt_q + 1'b1 : cnt_q;
   assign ovf_final = sat_q | (coin_ref_i & at_max);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q   <= 1'b0;
         sat_q     <= 1'b0;
         cnt_q     <= '0;
         valid_o   <= 1'b0;
         periods_o <= '0;
         ovf_o     <= 1'b0;
      end else begin
         valid_o <= coin_i & armed_q;
         if (coin_i) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
            sat_q   <= 1'b0;
            if (armed_q) begin
               periods_o <= cnt_final;
               ovf_o     <= ovf_final;
            end
         end else if (ref_rise_i) begin
            if (at_max) sat_q <= 1'b1;
            else        cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   if (TIME_EN) begin : g_time
      logic [TIME_W-1:0] tcnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            tcnt_q   <= '0;
            clocks_o <= '0;
         end else begin
            if (coin_i) tcnt_q <= {{(TIME_W-1){1'b0}}, 1'b1};
            else if (tcnt_q != TIME_MAX) tcnt_q <= tcnt_q + 1'b1;
            if (coin_i && armed_q) clocks_o <= tcnt_q;
         end
      end

      // R7
      tcnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!coin_i && tcnt_q != TIME_MAX) |=> (tcnt_q == $past(tcnt_q) + 1'b1));
   end else begin : g_no_time
      assign clocks_o = '0;
   end

   // R4
   valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);

   // R4
   arm_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (coin_i && !armed_q) |=> !valid_o);

   // R6
   no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (at_max && ref_rise_i && !coin_i) |=> (cnt_q == CNT_MAX && sat_q));

endmodule

// File: rtl/drift_meter.sv
module drift_meter
   import drift_meter_pkg::*;
#(
   parameter int CNT_W       = 24,
   parameter int TIME_W      = 32,
   parameter int WIN_W       = 8,
   parameter int BLANK_W     = 12,
   parameter int SYNC_STAGES = 2,
   parameter bit TIME_EN     = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               pwm_ref_i,
   input  logic               pwm_cmp_i,
   input  logic [WIN_W-1:0]   win_cfg_i,
   input  logic [BLANK_W-1:0] blank_cfg_i,
   output logic               meas_valid_o,
   output logic [CNT_W-1:0]   meas_periods_o,
   output logic               meas_ovf_o,
   output logic [TIME_W-1:0]  meas_clocks_o
);

   if (CNT_W < 4 || TIME_W < 4 || WIN_W < 1 || BLANK_W < 1) begin : g_bad_width
      $error("drift_meter: width parameter out of range");
   end

   logic [N_CH-1:0] pwm_vec, rise_vec;
   edge_pair_t      rises;
   logic            coin, coin_ref;

   assign pwm_vec[CH_REF] = pwm_ref_i;
   assign pwm_vec[CH_CMP] = pwm_cmp_i;

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      dm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .async_i (pwm_vec[ch]),
         .rise_o  (rise_vec[ch])
      );
   end

   assign rises.ref_e = rise_vec[CH_REF];
   assign rises.cmp   = rise_vec[CH_CMP];

   dm_coincide #(.WIN_W(WIN_W), .BLANK_W(BLANK_W)) u_coin (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rise_i      (rises),
      .win_cfg_i   (win_cfg_i),
      .blank_cfg_i (blank_cfg_i),
      .coin_o      (coin),
      .coin_ref_o  (coin_ref)
   );

   dm_interval #(.CNT_W(CNT_W), .TIME_W(TIME_W), .TIME_EN(TIME_EN)) u_intv (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .coin_i     (coin),
      .coin_ref_i (coin_ref),
      .ref_rise_i (rises.ref_e),
      .valid_o    (meas_valid_o),
      .periods_o  (meas_periods_o),
      .ovf_o      (meas_ovf_o),
      .clocks_o   (meas_clocks_o)
   );

   // R8
   hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !meas_valid_o |-> ($stable(meas_periods_o) && $stable(meas_ovf_o)));

endmodule

// File: tb/drift_meter_bench.sv
`timescale 1ns/1ps
module drift_meter_bench;

   localparam int CW = 6;
   localparam int TW = 10;
   localparam int WW = 8;
   localparam int BW = 8;
   localparam int CMAX = (1 << CW) - 1;
   localparam int TMAX = (1 << TW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_ref = 1'b0, pwm_cmp = 1'b0;
   logic [WW-1:0] win = '0;
   logic [BW-1:0] blank = '0;
   logic          valid, ovf, valid_nt, ovf_nt;
   logic [CW-1:0] periods, periods_nt;
   logic [TW-1:0] clocks, clocks_nt;

   always #2 clk = ~clk;   // 250 MHz

   drift_meter #(.CNT_W(CW), .TIME_W(TW), .WIN_W(WW), .BLANK_W(BW), .TIME_EN(1'b1)) u_drift_meter (
      .clk_i(clk), .rst_ni(rst_n), .pwm_ref_i(pwm_ref), .pwm_cmp_i(pwm_cmp),
      .win_cfg_i(win), .blank_cfg_i(blank), .meas_valid_o(valid),
      .meas_periods_o(periods), .meas_ovf_o(ovf), .meas_clocks_o(clocks));

   drift_meter #(.CNT_W(CW), .TIME_W(TW), .WIN_W(WW), .BLANK_W(BW), .TIME_EN(1'b0)) u_drift_meter_notime (
      .clk_i(clk), .rst_ni(rst_n), .pwm_ref_i(pwm_ref), .pwm_cmp_i(pwm_cmp),
      .win_cfg_i(win), .blank_cfg_i(blank), .meas_valid_o(valid_nt),
      .meas_periods_o(periods_nt), .meas_ovf_o(ovf_nt), .meas_clocks_o(clocks_nt));

   int errors = 0, checks = 0, cycles = 0;

   // ---------------- behavioural reference model ----------------
   logic [2:0] h_r, h_c;
   longint t, r_last, c_last, last_coin;
   bit r_live, c_live, armed;
   int refs, blank_left;
   bit exp_valid, exp_ovf;
   int exp_periods, exp_clocks;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         h_r = '0; h_c = '0; t = 0; r_last = 0; c_last = 0; last_coin = 0;
         r_live = 0; c_live = 0; armed = 0; refs = 0; blank_left = 0;
         exp_valid = 0; exp_ovf = 0; exp_periods = 0; exp_clocks = 0;
      end else begin
         bit rr, rc, r_open, c_open;
         rr = h_r[1] & ~h_r[2];
         rc = h_c[1] & ~h_c[2];
         h_r = {h_r[1:0], pwm_ref};
         h_c = {h_c[1:0], pwm_cmp};
         t++;
         r_open = r_live && ((t - r_last) <= longint'(win));
         c_open = c_live && ((t - c_last) <= longint'(win));
         exp_valid = 0;
         if (((rr && (rc || c_open)) || (rc && r_open)) && blank_left == 0) begin
            int n;
            n = refs + (rr ? 1 : 0);
            if (armed) begin
               exp_valid   = 1;
               exp_periods = (n > CMAX) ? CMAX : n;
               exp_ovf     = (n > CMAX);
               exp_clocks  = ((t - last_coin) > TMAX) ? TMAX : int'(t - last_coin);
            end
            armed = 1; refs = 0; last_coin = t; blank_left = int'(blank);
            r_live = 0; c_live = 0;
         end else begin
            if (rr) begin
               refs++; r_live = 1; r_last = t;
               if (blank_left > 0) blank_left--;
            end
            if (rc) begin
               c_live = 1; c_last = t;
            end
         end
      end
   end

   // ---------------- per-cycle comparison ----------------
   int n_strobe, first_per, first_clk;
   bit first_ovf, saw_one;

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         // R2 latency and R4 strobe
         chk(valid == exp_valid, "R2 R4 strobe", valid, exp_valid);
         chk(int'(periods) == exp_periods, "R6 R8 periods", periods, exp_periods);
         chk(ovf == exp_ovf, "R6 overflow", ovf, exp_ovf);
         chk(int'(clocks) == exp_clocks, "R7 clocks", clocks, exp_clocks);
         chk(clocks_nt == '0, "R7 time option off", clocks_nt, 0);
         chk(valid_nt == exp_valid, "R4 strobe no-time copy", valid_nt, exp_valid);
         if (valid) begin
            if (n_strobe == 0) begin
               first_per = periods; first_clk = clocks; first_ovf = ovf;
            end
            n_strobe++;
            if (periods == 1) saw_one = 1;
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic run_case(input int rp, input int cp, input int coff, input int w,
                           input int b, input int ncyc);
      int rph, cph;
      @(negedge clk);
      rst_n = 0; pwm_ref = 0; pwm_cmp = 0;
      win = WW'(w); blank = BW'(b);
      repeat (3) @(negedge clk);
      // R1
      chk(valid == 0 && periods == 0 && ovf == 0 && clocks == 0, "R1 reset state",
          {valid, ovf, periods, clocks}, 0);
      rst_n = 1;
      n_strobe = 0; saw_one = 0; first_per = -1; first_clk = -1; first_ovf = 0;
      rph = rp - 1;
      cph = cp - 1 - coff;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         rph = (rph + 1) % rp;
         cph = (cph + 1) % cp;
         pwm_ref = (rph < rp / 2);
         pwm_cmp = (cph < cp / 2);
      end
      @(negedge clk);
   endtask

   initial begin
      // A: exact line-ups, ref 10 clocks, cmp 11 clocks
      run_case(10, 11, 0, 0, 0, 1200);
      chk(first_per == 11, "R6 first count 10/11", first_per, 11);
      chk(first_clk == 110, "R7 first interval 10/11", first_clk, 110);
      chk(n_strobe >= 5, "R4 strobe count", n_strobe, 5);
      // B: window 1 catches one-clock near misses
      run_case(10, 11, 0, 1, 0, 1200);
      chk(saw_one == 1, "R3 near-miss within window", saw_one, 1);
      // C: blanking suppresses the doubled count
      run_case(10, 11, 0, 1, 3, 1200);
      chk(saw_one == 0, "R5 blanking", saw_one, 0);
      chk(n_strobe > 0, "R5 strobes remain", n_strobe, 1);
      // D: phase offset, ref 8, cmp 9
      run_case(8, 9, 3, 0, 0, 1200);
      chk(first_per == 9, "R6 count 8/9 offset", first_per, 9);
      chk(first_clk == 72, "R7 interval 8/9", first_clk, 72);
      // E: saturation, ref 100, cmp 101
      run_case(100, 101, 0, 0, 0, 31000);
      chk(first_per == CMAX && first_ovf == 1, "R6 saturation", first_per, CMAX);
      chk(first_clk == TMAX, "R7 clock saturation", first_clk, TMAX);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule